// File: doc/BRIEF.md
# Gray-Coded Counter Clock-Domain Synchronizer

This block moves a counter value from one clock domain into a second, unrelated clock domain. On the source side the binary count is converted to Gray code and captured in a register clocked by the source clock. Each legal step of the counter changes exactly one bit of that registered word. On the destination side the word passes through a chain of destination-clocked flops. The last stage is decoded back to binary and registered as the output.

The counter may count up, count down or hold. It must never move by more than one position per source cycle. Its range is the full power of two set by the width, so the wrap from the top value to zero also changes a single Gray bit. A simulation checker inside the block flags any source cycle in which the input moves further than that. Each domain has its own asynchronous active-low reset.

Top module: `gray_count_sync`

## Requirements
- R1: Between two consecutive source clock edges after reset, `src_count` may change by +1, -1 or 0, counted modulo 2^WIDTH. Any larger move is reported as an error by the built-in checker.
- R2: The source register holds the Gray form g = b ^ (b >> 1) of the input. For WIDTH 3 this maps 3 to 010, 4 to 110 and 5 to 111. Each legal step changes at most one bit of the register.
- R3: The Gray word is registered on `src_clk` before it leaves the source domain. The destination never samples conversion logic directly.
- R4: The destination samples the registered Gray word through SYNC_STAGES (at least 2) flops on `dst_clk`, followed by one output register. A source change captured at a source edge appears on `dst_count` at the (SYNC_STAGES+1)th destination edge after it, and not before.
- R5: The output register holds the binary decode of the last synchronizer stage, so a static source value is reproduced exactly on `dst_count`.
- R6: While `dst_rst_n` is low, `dst_count` reads 0. While `src_rst_n` is low, the source register holds 0, so the destination settles to 0.
- R7: Under any sequence of legal up, down and hold steps, every value seen on `dst_count` is a value that `src_count` held earlier.
- R8: The wrap from 2^WIDTH-1 to 0 and from 0 to 2^WIDTH-1 in either direction is carried through correctly, with only the old or the new value appearing at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_count | input | WIDTH | Binary counter value in the source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_count | output | WIDTH | Binary counter value recovered in the destination domain |

## Verification
The bench attacks the latency edge by changing the source once and sampling right before and right after the (SYNC_STAGES+1)th destination edge. A design with a missing or extra stage shows the new value one edge early or late. Step sequences through 3, 4 and 5 and across the wrap point expose a wrong Gray encoding or a wrong decode, which shows up as output values the source never held or as a settled value that differs from the source. A long random walk of up, down and hold steps at unrelated clock rates checks every destination sample against the set of values driven so far. Each domain's reset is also applied on its own, to catch a reset that leaves stale state in either domain.

// File: rtl/gray_count_sync.sv
module gray_count_sync #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             src_clk,
  input  logic             src_rst_n,
  input  logic [WIDTH-1:0] src_count,
  input  logic             dst_clk,
  input  logic             dst_rst_n,
  output logic [WIDTH-1:0] dst_count
);

  localparam logic [WIDTH-1:0] STEP_UP   = WIDTH'(1);
  localparam logic [WIDTH-1:0] STEP_DOWN = {WIDTH{1'b1}};

  if (SYNC_STAGES < 2) begin : g_bad_depth
    $error("SYNC_STAGES must be at least 2");
  end

  function automatic logic [WIDTH-1:0] gray_to_bin(input logic [WIDTH-1:0] g);
    logic [WIDTH-1:0] b;
    b[WIDTH-1] = g[WIDTH-1];
    for (int i = WIDTH - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // source domain: registered Gray word
  logic [WIDTH-1:0] src_gray_q;
  always_ff @(posedge src_clk or negedge src_rst_n)
    if (!src_rst_n) src_gray_q <= '0;
    else            src_gray_q <= src_count ^ (src_count >> 1);

  // destination domain: metastability chain (cdc_meta_ marks the synchronizer flops)
  logic [SYNC_STAGES-1:0][WIDTH-1:0] cdc_meta_q;
  always_ff @(posedge dst_clk or negedge dst_rst_n)
    if (!dst_rst_n) cdc_meta_q <= '0;
    else            cdc_meta_q <= {cdc_meta_q[SYNC_STAGES-2:0], src_gray_q};

  logic [WIDTH-1:0] dst_bin_q;
  always_ff @(posedge dst_clk or negedge dst_rst_n)
    if (!dst_rst_n) dst_bin_q <= '0;
    else            dst_bin_q <= gray_to_bin(cdc_meta_q[SYNC_STAGES-1]);

  assign dst_count = dst_bin_q;

  // simulation checker state
  logic [WIDTH-1:0] chk_prev_q;
  logic [1:0]       chk_src_age_q;
  logic             chk_dst_live_q;
  logic [WIDTH-1:0] chk_delta;

  always_ff @(posedge src_clk or negedge src_rst_n)
    if (!src_rst_n) begin
      chk_prev_q    <= '0;
      chk_src_age_q <= '0;
    end else begin
      chk_prev_q <= src_count;
      if (chk_src_age_q != 2'd3) chk_src_age_q <= chk_src_age_q + 2'd1;
    end

  always_ff @(posedge dst_clk or negedge dst_rst_n)
    if (!dst_rst_n) chk_dst_live_q <= 1'b0;
    else            chk_dst_live_q <= 1'b1;

  assign chk_delta = src_count - chk_prev_q;

  AST_STEP_LIMIT: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (chk_src_age_q != 2'd0) |-> (chk_delta == '0 || chk_delta == STEP_UP || chk_delta == STEP_DOWN)); // R1

  AST_GRAY_ONE_BIT: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (chk_src_age_q >= 2'd2) |-> ($countones(src_gray_q ^ $past(src_gray_q)) <= 1)); // R2

  AST_DECODE_MATCH: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    chk_dst_live_q |-> ((dst_count ^ (dst_count >> 1)) == $past(cdc_meta_q[SYNC_STAGES-1]))); // R5

  always @(posedge dst_clk)
    if (!dst_rst_n) AST_RESET_CLEAR: assert (dst_count == '0); // R6

endmodule

// File: tb/gray_count_sync_bench.sv
module gray_count_sync_bench;
  localparam int WIDTH  = 8;
  localparam int STAGES = 2;
  localparam int RANGE  = 1 << WIDTH;

  logic src_clk = 1'b0, dst_clk = 1'b0;
  logic src_rst_n = 1'b0, dst_rst_n = 1'b0;
  logic [WIDTH-1:0] src_count = '0;
  logic [WIDTH-1:0] dst_count;

  int checks = 0, errors = 0;
  bit seen [RANGE];
  bit walking = 1'b0;

  always #10 src_clk = ~src_clk;
  initial begin
    #2;
    forever #7 dst_clk = ~dst_clk;
  end

  gray_count_sync #(.WIDTH(WIDTH), .SYNC_STAGES(STAGES)) u_gray_count_sync (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_count(src_count),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_count(dst_count));

  task automatic check_eq(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [WIDTH-1:0] v);
    @(negedge src_clk);
    src_count = v;
    seen[v] = 1'b1;
  endtask

  task automatic settle();
    @(posedge src_clk);
    repeat (STAGES + 3) @(posedge dst_clk);
    #1;
  endtask

  task automatic clear_seen(input logic [WIDTH-1:0] keep);
    for (int i = 0; i < RANGE; i++) seen[i] = 1'b0;
    seen[keep] = 1'b1;
  endtask

  task automatic walk_to(input logic [WIDTH-1:0] target);
    while (src_count != target) drive(src_count + 1'b1);
  endtask

  task automatic t_reset();
    #1;
    check_eq("R6 reset", dst_count, '0);
    repeat (3) @(posedge src_clk);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    settle();
    check_eq("R6 after release", dst_count, '0);
  endtask

  task automatic t_latency();
    walk_to(8'd40);
    settle();
    check_eq("R5 static", dst_count, 8'd40);
    drive(8'd41);
    @(posedge src_clk);
    repeat (STAGES) @(posedge dst_clk);
    #1;
    check_eq("R4 not early", dst_count, 8'd40);
    @(posedge dst_clk);
    #1;
    check_eq("R4 on time", dst_count, 8'd41);
    drive(8'd40);
    @(posedge src_clk);
    repeat (STAGES) @(posedge dst_clk);
    #1;
    check_eq("R4 down not early", dst_count, 8'd41);
    @(posedge dst_clk);
    #1;
    check_eq("R4 down on time", dst_count, 8'd40);
  endtask

  task automatic t_gray_steps();
    walk_to(8'd3);
    settle();
    check_eq("R2 value 3", dst_count, 8'd3);
    drive(8'd4); settle();
    check_eq("R2 value 4", dst_count, 8'd4);
    drive(8'd5); settle();
    check_eq("R2 value 5", dst_count, 8'd5);
    drive(8'd4); settle();
    check_eq("R2 back to 4", dst_count, 8'd4);
    drive(8'd5); drive(8'd6); drive(8'd7); drive(8'd8); settle();
    check_eq("R3 fast run", dst_count, 8'd8);
  endtask

  task automatic t_wrap();
    walk_to(8'd255);
    settle();
    check_eq("R8 top value", dst_count, 8'd255);
    drive(8'd0);
    repeat (STAGES + 3) begin
      @(posedge dst_clk); #1;
      checks++;
      if (dst_count != 8'd255 && dst_count != 8'd0) begin
        errors++;
        $display("FAIL R8 wrap up: actual %0d expected 255 or 0", dst_count);
      end
    end
    check_eq("R8 wrap up", dst_count, 8'd0);
    drive(8'd255);
    settle();
    check_eq("R8 wrap down", dst_count, 8'd255);
    drive(8'd0);
    settle();
  endtask

  task automatic t_random_walk();
    clear_seen(src_count);
    walking = 1'b1;
    fork
      begin
        for (int n = 0; n < 600; n++) begin
          int r = $urandom_range(0, 2);
          if (r == 0)      drive(src_count + 1'b1);
          else if (r == 1) drive(src_count - 1'b1);
          else             drive(src_count);
        end
        walking = 1'b0;
      end
      begin
        while (walking) begin
          @(posedge dst_clk); #1;
          checks++;
          if (!seen[dst_count]) begin
            errors++;
            $display("FAIL R7 unseen value: actual %0d expected a driven value", dst_count);
          end
        end
      end
    join
    settle();
    check_eq("R7 settled", dst_count, src_count);
  endtask

  task automatic t_domain_resets();
    walk_to(8'd77);
    settle();
    @(negedge dst_clk);
    dst_rst_n = 1'b0;
    #1;
    check_eq("R6 dst reset", dst_count, '0);
    repeat (2) @(negedge dst_clk);
    check_eq("R6 dst reset hold", dst_count, '0);
    dst_rst_n = 1'b1;
    settle();
    check_eq("R6 dst recovery", dst_count, 8'd77);
    @(negedge src_clk);
    src_rst_n = 1'b0;
    settle();
    check_eq("R6 src reset", dst_count, '0);
    @(negedge src_clk);
    src_count = '0;
    src_rst_n = 1'b1;
    settle();
    check_eq("R6 src recovery", dst_count, '0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_latency();
        t_gray_steps();
        t_wrap();
        t_random_walk();
        t_domain_resets();
      end
      begin
        repeat (100000) @(posedge src_clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule